// File: doc/BRIEF.md
# Five-Stage Pipeline Datapath with Interstage Buffers

This block is a slice of an in-order 32-bit datapath with five stages: fetch, decode, execute, memory access and write-back. It handles register-to-register ALU instructions, word loads and word stores. Four clocked buffers separate the stages. Each buffer carries every operand, immediate and control bit that its instruction still needs further down the pipe. A memory write or register write therefore happens only when its own instruction reaches the stage that performs it, never because of whatever instruction is being decoded at that moment.

Control is decoded once, in the decode stage, and then travels forward with the instruction. The destination register number also rides along to write-back. Instruction memory, data memory, the register file and the ALU are all internal. A preload port fills both memories while the block is held in reset. Two read-only peek ports show one register and one data word. The block does not detect hazards, forward operands or stall, so the program has to keep dependent instructions far enough apart.

Top module: `pipe5_core`

## Requirements
- R1: Register instructions have opcode bits [31:26] = 0x00, source A in [25:21], source B in [20:16], destination in [15:11] and function code in [5:0]. The function codes are 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or and 0x2A signed set-less-than (result 1 or 0). Any other function code does nothing, so the all-zero word is a bubble.
- R2: A load has opcode 0x23. It writes register [20:16] with the data word at byte address reg[25:21] + sign-extended [15:0]. The word index is address bits [DAW+1:2].
- R3: A store has opcode 0x2B. It writes register [20:16] to the data word at the same kind of address, and it writes no register.
- R4: The data-memory write strobe of a store is asserted in the store's own memory cycle, two cycles after it sat in decode. Instructions placed k words apart in the program strobe k cycles apart. A load or register instruction commits its register write exactly one cycle after a store at the same program position would strobe.
- R5: A register write uses the destination of the instruction that is in write-back. Loads write back the memory data and register instructions write back the ALU result. Commits appear on rf_wr_idx in program order.
- R6: Register 0 always reads as zero, and writes to it leave it unchanged.
- R7: A read in decode of a register that write-back is writing in the same cycle returns the new value. Two bubbles between a producer and its consumer are therefore enough.
- R8: rst_n is an active-low asynchronous reset whose release takes effect after two rising clock edges. Reset clears the program counter, every interstage buffer and the register file. No write strobe is asserted while reset is held.
- R9: When an instruction is in the memory stage, mem_br_target equals its PC+4 plus its sign-extended immediate times four. mem_zero is high exactly when its ALU result is zero.
- R10: With pre_en high, pre_data is written to instruction word pre_idx when pre_to_dmem = 0, or to data word pre_idx when it is 1. peek_reg_data and peek_mem_data read one register and one data word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_en | input | 1 | Preload write enable |
| pre_to_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pre_idx | input | PW | Preload word index |
| pre_data | input | 32 | Preload word |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem_idx | input | DAW | Data word index to observe |
| peek_mem_data | output | 32 | Value of the observed data word |
| dmem_wr_en | output | 1 | Data-memory write strobe of the instruction in the memory stage |
| dmem_wr_addr | output | 32 | Byte address of that write |
| dmem_wr_data | output | 32 | Data of that write |
| rf_wr_en | output | 1 | Register commit strobe of the instruction in write-back |
| rf_wr_idx | output | 5 | Destination of that commit |
| rf_wr_data | output | 32 | Value of that commit |
| mem_br_target | output | 32 | Branch target held in the memory-stage buffer |
| mem_zero | output | 1 | ALU zero flag held in the memory-stage buffer |

## Verification
Two of the block's functions can land in the same cycle: a write-back commit to a register, and a decode-stage read of that same register. To provoke this, the program places a producer and its consumer with exactly two bubbles between them. The consumer's result, read through the peek port after the pipe drains, must show the new value. The bench also checks the cycle spacing between each store strobe and each register commit against the program positions. A store that fired while an earlier instruction held the memory stage, or a commit that used the wrong stage's destination, would then show up as a timing or index mismatch.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  // control word produced once in decode
  typedef struct packed {
    logic    reg_write;
    logic    mem_to_reg;
    logic    mem_write;
    logic    use_imm;
    logic    dst_is_rd;
    alu_op_e alu_op;
  } dec_ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } fd_buf_t;

  typedef struct packed {
    logic            reg_write;
    logic            mem_to_reg;
    logic            mem_write;
    logic            use_imm;
    alu_op_e         alu_op;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] imm;
    logic [RIDX-1:0] dst;
  } dx_buf_t;

  typedef struct packed {
    logic            reg_write;
    logic            mem_to_reg;
    logic            mem_write;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] alu_res;
    logic            zero;
    logic [XLEN-1:0] b_val;
    logic [RIDX-1:0] dst;
  } xm_buf_t;

  typedef struct packed {
    logic            reg_write;
    logic            mem_to_reg;
    logic [XLEN-1:0] rdata;
    logic [XLEN-1:0] alu_res;
    logic [RIDX-1:0] dst;
  } mw_buf_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output dec_ctrl_t  ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_write = 1'b0;   // unknown function: bubble
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.use_imm    = 1'b1;
      end
      OPC_STORE: begin
        ctrl.mem_write = 1'b1;
        ctrl.use_imm   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XW = 32
) (
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] res,
  output logic          zero
);

  always_comb begin
    case (op)
      ALU_SUB: res = a - b;
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_SLT: res = {{(XW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: res = a + b;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter  int XW   = 32,
  parameter  int AW   = 5,
  parameter  int NRD  = 3,
  localparam int NREG = 1 << AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [XW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][XW-1:0]  rdata
);

  logic [NREG-1:0][XW-1:0] regs_q, regs_d;
  logic                    wr_hit;

  assign wr_hit = we && (waddr != '0);

  always_comb begin
    regs_d = regs_q;
    if (wr_hit) regs_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      regs_q <= '0;
    else if (wr_hit) regs_q <= regs_d;
  end

  // each read port sees a same-cycle write
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if (raddr[g] == '0)                    rdata[g] = '0;
      else if (wr_hit && waddr == raddr[g])  rdata[g] = wdata;
      else                                   rdata[g] = regs_q[raddr[g]];
    end
  end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int IMEM_WORDS = 128,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int PW  = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_en,
  input  logic            pre_to_dmem,
  input  logic [PW-1:0]   pre_idx,
  input  logic [31:0]     pre_data,
  input  logic [4:0]      peek_reg,
  output logic [31:0]     peek_reg_data,
  input  logic [DAW-1:0]  peek_mem_idx,
  output logic [31:0]     peek_mem_data,
  output logic            dmem_wr_en,
  output logic [31:0]     dmem_wr_addr,
  output logic [31:0]     dmem_wr_data,
  output logic            rf_wr_en,
  output logic [4:0]      rf_wr_idx,
  output logic [31:0]     rf_wr_data,
  output logic [31:0]     mem_br_target,
  output logic            mem_zero
);

  // ---------------- reset release ----------------
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // ---------------- state ----------------
  logic [XLEN-1:0] pc_q, pc_d;
  fd_buf_t fd_q, fd_d;
  dx_buf_t dx_q, dx_d;
  xm_buf_t xm_q, xm_d;
  mw_buf_t mw_q, mw_d;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [XLEN-1:0] if_pc4;
  logic [XLEN-1:0] if_instr;

  assign if_pc4   = pc_q + 32'd4;
  assign if_instr = imem[pc_q[IAW+1:2]];
  assign pc_d     = if_pc4;

  always_ff @(posedge clk) begin
    if (pre_en && !pre_to_dmem) imem[pre_idx[IAW-1:0]] <= pre_data;
  end

  always_comb begin
    fd_d.pc4   = if_pc4;
    fd_d.instr = if_instr;
  end

  // ---------------- decode ----------------
  logic [XLEN-1:0]            id_instr;
  logic [RIDX-1:0]            id_rs, id_rt, id_rd;
  dec_ctrl_t                  id_ctrl;
  logic [2:0][RIDX-1:0]       rf_raddr;
  logic [2:0][XLEN-1:0]       rf_rdata;
  logic [XLEN-1:0]            wb_value;

  assign id_instr = fd_q.instr;
  assign id_rs    = id_instr[25:21];
  assign id_rt    = id_instr[20:16];
  assign id_rd    = id_instr[15:11];
  assign rf_raddr = {peek_reg, id_rt, id_rs};

  pipe5_decode u_dec (
    .opcode (id_instr[31:26]),
    .funct  (id_instr[5:0]),
    .ctrl   (id_ctrl)
  );

  pipe5_regfile #(.XW(XLEN), .AW(RIDX), .NRD(3)) u_rf (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (mw_q.reg_write),
    .waddr (mw_q.dst),
    .wdata (wb_value),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_comb begin
    dx_d.reg_write  = id_ctrl.reg_write;
    dx_d.mem_to_reg = id_ctrl.mem_to_reg;
    dx_d.mem_write  = id_ctrl.mem_write;
    dx_d.use_imm    = id_ctrl.use_imm;
    dx_d.alu_op     = id_ctrl.alu_op;
    dx_d.pc4        = fd_q.pc4;
    dx_d.a_val      = rf_rdata[0];
    dx_d.b_val      = rf_rdata[1];
    dx_d.imm        = {{16{id_instr[15]}}, id_instr[15:0]};
    dx_d.dst        = id_ctrl.dst_is_rd ? id_rd : id_rt;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_b, ex_res;
  logic            ex_zero;

  assign ex_b = dx_q.use_imm ? dx_q.imm : dx_q.b_val;

  pipe5_alu #(.XW(XLEN)) u_alu (
    .op   (dx_q.alu_op),
    .a    (dx_q.a_val),
    .b    (ex_b),
    .res  (ex_res),
    .zero (ex_zero)
  );

  always_comb begin
    xm_d.reg_write  = dx_q.reg_write;
    xm_d.mem_to_reg = dx_q.mem_to_reg;
    xm_d.mem_write  = dx_q.mem_write;
    xm_d.br_target  = dx_q.pc4 + {dx_q.imm[XLEN-3:0], 2'b00};
    xm_d.alu_res    = ex_res;
    xm_d.zero       = ex_zero;
    xm_d.b_val      = dx_q.b_val;
    xm_d.dst        = dx_q.dst;
  end

  // ---------------- memory ----------------
  logic [DAW-1:0] mem_idx;

  assign mem_idx = xm_q.alu_res[DAW+1:2];

  always_ff @(posedge clk) begin
    if (pre_en && pre_to_dmem) dmem[pre_idx[DAW-1:0]] <= pre_data;
    else if (xm_q.mem_write)   dmem[mem_idx]          <= xm_q.b_val;
  end

  always_comb begin
    mw_d.reg_write  = xm_q.reg_write;
    mw_d.mem_to_reg = xm_q.mem_to_reg;
    mw_d.rdata      = dmem[mem_idx];
    mw_d.alu_res    = xm_q.alu_res;
    mw_d.dst        = xm_q.dst;
  end

  // ---------------- write-back ----------------
  assign wb_value = mw_q.mem_to_reg ? mw_q.rdata : mw_q.alu_res;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_q <= '0;
      fd_q <= '0;
      dx_q <= '0;
      xm_q <= '0;
      mw_q <= '0;
    end else begin
      pc_q <= pc_d;
      fd_q <= fd_d;
      dx_q <= dx_d;
      xm_q <= xm_d;
      mw_q <= mw_d;
    end
  end

  // ---------------- outputs ----------------
  assign peek_reg_data = rf_rdata[2];
  assign peek_mem_data = dmem[peek_mem_idx];
  assign dmem_wr_en    = xm_q.mem_write;
  assign dmem_wr_addr  = xm_q.alu_res;
  assign dmem_wr_data  = xm_q.b_val;
  assign rf_wr_en      = mw_q.reg_write;
  assign rf_wr_idx     = mw_q.dst;
  assign rf_wr_data    = wb_value;
  assign mem_br_target = xm_q.br_target;
  assign mem_zero      = xm_q.zero;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2]};

endmodule

module pipe5_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] id_instr,
  input logic        dmem_wr_en,
  input logic        rf_wr_en,
  input logic [4:0]  rf_wr_idx
);

  logic       id_store, id_load, id_alu;
  logic [4:0] id_dst;

  assign id_store = (id_instr[31:26] == 6'h2B);
  assign id_load  = (id_instr[31:26] == 6'h23);
  assign id_alu   = (id_instr[31:26] == 6'h00) &&
                    (id_instr[5:0] == 6'h20 || id_instr[5:0] == 6'h22 ||
                     id_instr[5:0] == 6'h24 || id_instr[5:0] == 6'h25 ||
                     id_instr[5:0] == 6'h2A);
  assign id_dst   = id_load ? id_instr[20:16] : id_instr[15:11];

  // R4: a store strobes memory two cycles after decode
  p_store_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_store |-> ##2 dmem_wr_en);

  // R4: no strobe unless a store was decoded two cycles earlier
  p_strobe_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr_en |-> $past(id_store, 2));

  // R3: a store never produces a register commit
  p_store_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    id_store |-> ##3 !rf_wr_en);

  // R5: commits come only from loads or valid register instructions
  p_commit_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> $past(id_load || id_alu, 3));

  // R5: commit index is the destination of the instruction now in write-back
  p_commit_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_wr_idx == $past(id_dst, 3)));

  // R8: no write strobe while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert (!dmem_wr_en && !rf_wr_en);
    end
  end

endmodule

bind pipe5_core pipe5_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .id_instr   (id_instr),
  .dmem_wr_en (dmem_wr_en),
  .rf_wr_en   (rf_wr_en),
  .rf_wr_idx  (rf_wr_idx)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

  localparam int IW = 128;
  localparam int DW = 64;
  localparam int PW = 7;
  localparam int NROW = 17;

  localparam logic [5:0] OP_LD = 6'h23;
  localparam logic [5:0] OP_ST = 6'h2B;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_m(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [1:0]  gap;   // bubbles after this instruction
    logic        kmem;  // 1: check data word idx, 0: check register idx
    logic [5:0]  idx;
    logic [31:0] val;
  } row_t;

  localparam row_t TBL [NROW] = '{
    '{enc_m(OP_LD, 0, 1, 16'h0000),    2'd3, 1'b0, 6'd1,  32'h00000007},
    '{enc_m(OP_LD, 0, 2, 16'h0004),    2'd3, 1'b0, 6'd2,  32'hFFFFFFFD},
    '{enc_m(OP_LD, 0, 3, 16'h0008),    2'd3, 1'b0, 6'd3,  32'h12345678},
    '{enc_m(OP_LD, 0, 4, 16'h000C),    2'd3, 1'b0, 6'd4,  32'h0F0F00FF},
    '{enc_r(1, 2, 5, 6'h20),           2'd3, 1'b0, 6'd5,  32'h00000004},
    '{enc_r(1, 2, 6, 6'h22),           2'd3, 1'b0, 6'd6,  32'h0000000A},
    '{enc_r(3, 4, 7, 6'h24),           2'd3, 1'b0, 6'd7,  32'h02040078},
    '{enc_r(3, 4, 8, 6'h25),           2'd3, 1'b0, 6'd8,  32'h1F3F56FF},
    '{enc_r(2, 1, 9, 6'h2A),           2'd3, 1'b0, 6'd9,  32'h00000001},
    '{enc_r(1, 2, 10, 6'h2A),          2'd3, 1'b0, 6'd10, 32'h00000000},
    '{enc_m(OP_ST, 0, 3, 16'h0010),    2'd3, 1'b1, 6'd4,  32'h12345678},
    '{enc_m(OP_ST, 5, 6, 16'hFFFC),    2'd3, 1'b1, 6'd0,  32'h0000000A},
    '{enc_m(OP_LD, 5, 11, 16'h000C),   2'd3, 1'b0, 6'd11, 32'h12345678},
    '{enc_r(1, 1, 0, 6'h20),           2'd3, 1'b0, 6'd0,  32'h00000000},
    '{enc_r(1, 1, 13, 6'h20),          2'd2, 1'b0, 6'd13, 32'h0000000E},
    '{enc_r(13, 0, 14, 6'h25),         2'd3, 1'b0, 6'd14, 32'h0000000E},
    '{enc_m(OP_ST, 0, 1, 16'h0014),    2'd3, 1'b1, 6'd5,  32'h00000007}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          pre_en, pre_to_dmem;
  logic [PW-1:0] pre_idx;
  logic [31:0]   pre_data;
  logic [4:0]    peek_reg;
  logic [31:0]   peek_reg_data;
  logic [5:0]    peek_mem_idx;
  logic [31:0]   peek_mem_data;
  logic          dmem_wr_en, rf_wr_en, mem_zero;
  logic [31:0]   dmem_wr_addr, dmem_wr_data, rf_wr_data, mem_br_target;
  logic [4:0]    rf_wr_idx;

  pipe5_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_pipe5_core (
    .clk(clk), .rst_n(rst_n),
    .pre_en(pre_en), .pre_to_dmem(pre_to_dmem), .pre_idx(pre_idx), .pre_data(pre_data),
    .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
    .peek_mem_idx(peek_mem_idx), .peek_mem_data(peek_mem_data),
    .dmem_wr_en(dmem_wr_en), .dmem_wr_addr(dmem_wr_addr), .dmem_wr_data(dmem_wr_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_br_target(mem_br_target), .mem_zero(mem_zero)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit run   = 1'b0;
  int cyc   = 0;

  // commit log sampled on falling edges
  int          n_dm = 0, n_rf = 0;
  int          dm_cyc [8];
  logic [31:0] dm_addr [8], dm_data [8], dm_br [8];
  logic        dm_zero [8];
  int          rf_cyc [32];
  logic [4:0]  rf_idx [32];
  logic [31:0] rf_dat [32];

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      if (dmem_wr_en && n_dm < 8) begin
        dm_cyc[n_dm] = cyc; dm_addr[n_dm] = dmem_wr_addr; dm_data[n_dm] = dmem_wr_data;
        dm_br[n_dm] = mem_br_target; dm_zero[n_dm] = mem_zero;
        n_dm++;
      end
      if (rf_wr_en && n_rf < 32) begin
        rf_cyc[n_rf] = cyc; rf_idx[n_rf] = rf_wr_idx; rf_dat[n_rf] = rf_wr_data;
        n_rf++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(bit to_d, int idx, logic [31:0] d);
    pre_en = 1'b1; pre_to_dmem = to_d; pre_idx = PW'(idx); pre_data = d;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 110);
      summary();
      $finish;
    end
  end

  int pos_tbl [NROW];

  initial begin
    rst_n = 1'b0; pre_en = 1'b0; pre_to_dmem = 1'b0; pre_idx = '0; pre_data = '0;
    peek_reg = '0; peek_mem_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R8: quiet outputs and cleared registers under reset
    chk("R8 dmem strobe in reset", 32'(dmem_wr_en), 32'd0);
    chk("R8 rf strobe in reset", 32'(rf_wr_en), 32'd0);
    peek_reg = 5'd1; #1;
    chk("R8 register cleared", peek_reg_data, 32'd0);

    // R10: preload both memories
    for (int i = 0; i < IW; i++) preload(1'b0, i, 32'd0);
    for (int i = 0; i < DW; i++) preload(1'b1, i, 32'd0);
    preload(1'b1, 0, 32'h00000007);
    preload(1'b1, 1, 32'hFFFFFFFD);
    preload(1'b1, 2, 32'h12345678);
    preload(1'b1, 3, 32'h0F0F00FF);
    begin
      int p = 0;
      for (int r = 0; r < NROW; r++) begin
        pos_tbl[r] = p;
        preload(1'b0, p, TBL[r].ins);
        p += 1 + int'(TBL[r].gap);
      end
    end
    pre_en = 1'b0;
    peek_mem_idx = 6'd3; #1;
    chk("R10 peek preloaded word", peek_mem_data, 32'h0F0F00FF);

    // run the program and drain
    @(negedge clk);
    rst_n = 1'b1; run = 1'b1;
    repeat (110) @(negedge clk);
    run = 1'b0;

    // R1 R2 R3 R6 R7: architectural state from the vector table
    for (int r = 0; r < NROW; r++) begin
      if (TBL[r].kmem) begin
        peek_mem_idx = TBL[r].idx; #1;
        chk($sformatf("R3 data word %0d", TBL[r].idx), peek_mem_data, TBL[r].val);
      end else begin
        peek_reg = TBL[r].idx[4:0]; #1;
        chk($sformatf("R1/R2/R6/R7 register %0d", TBL[r].idx), peek_reg_data, TBL[r].val);
      end
    end
    peek_reg = 5'd1; #1;
    chk("R3 store source register unchanged", peek_reg_data, 32'h00000007);

    // R4 R5 R9: commit order, indices, data and timing
    begin
      int si = 0, ri = 0, base = 0;
      bit have_base = 1'b0;
      for (int r = 0; r < NROW; r++) begin
        logic [5:0] op;
        logic [5:0] fn;
        op = TBL[r].ins[31:26];
        fn = TBL[r].ins[5:0];
        if (op == OP_ST && si < n_dm) begin
          if (!have_base) begin base = dm_cyc[si] - pos_tbl[r]; have_base = 1'b1; end
          chk("R4 store strobe cycle", 32'(dm_cyc[si]), 32'(base + pos_tbl[r]));
          chk("R3 store address", dm_addr[si], {24'd0, TBL[r].idx, 2'b00});
          chk("R3 store data", dm_data[si], TBL[r].val);
          chk("R9 branch target", dm_br[si],
              32'(pos_tbl[r] * 4 + 4) + {{14{TBL[r].ins[15]}}, TBL[r].ins[15:0], 2'b00});
          chk("R9 zero flag", 32'(dm_zero[si]), 32'(TBL[r].idx == 6'd0));
          si++;
        end else if ((op == OP_LD || (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 ||
                     fn == 6'h24 || fn == 6'h25 || fn == 6'h2A))) && ri < n_rf) begin
          chk("R5 commit destination", 32'(rf_idx[ri]),
              32'(op == OP_LD ? TBL[r].ins[20:16] : TBL[r].ins[15:11]));
          if (TBL[r].idx != 6'd0)
            chk("R5 commit value", rf_dat[ri], TBL[r].val);
          if (have_base)
            chk("R4 commit one cycle after store position", 32'(rf_cyc[ri]),
                32'(base + pos_tbl[r] + 1));
          ri++;
        end
      end
      chk("R4 store strobe count", 32'(n_dm), 32'd3);
      chk("R5 commit count", 32'(n_rf), 32'd14);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule